// File: doc/BRIEF.md
# Camera Register Setup Sequencer

After reset, this block writes a fixed set of configuration registers in an image sensor over a parallel bus that behaves like an asynchronous memory. The bus has an address, a write-data bus and three active-low strobes: chip select, write enable and output enable. No processor is needed to configure the camera. The block first runs a startup delay of a programmable number of clock cycles, which gives the sensor time to settle. It then writes the horizontal window size register, followed by the vertical window size register.

Each register write takes three phases: a setup phase, a hold phase and a release phase. The length of each phase is a parameter given in clock cycles, so that the nanosecond timing the sensor needs can be met at any clock rate. When no write is in progress, the bus sits at fixed idle levels. When the last write has been released, a completion flag rises and stays high until the next reset. The camera's capture logic can use this flag to start taking frames.

The number of registers, the address of the first register, the value written to each register, the bus widths and all phase lengths are parameters. Register i is written at address BASE_ADDR + i, using data slot i of a packed parameter.

Top module: `cam_setup_seq`

## Requirements
- R1: While reset (active-low `rst_n`, asynchronous) is asserted, the outputs hold these values: `bus_addr`=0, `bus_csb`=1, `bus_web`=1, `bus_oeb`=0, `bus_data_en`=0, `bus_data`=0 and `setup_done`=0.
- R2: After reset is released, the bus stays idle for exactly WAIT_COUNT+1 clock cycles. In the cycle after that, the first write's setup phase begins.
- R3: The phases of one write always run in the order setup, hold, release. They last T_SETUP, T_HOLD and T_RELEASE cycles respectively. Chip select is low for exactly T_SETUP+T_HOLD consecutive cycles.
- R4: During the setup and hold phases, the outputs are `bus_csb`=0, `bus_web`=0, `bus_oeb`=1 and `bus_data_en`=1, with the register's address and data driven.
- R5: During the release phase, the outputs are `bus_csb`=1, `bus_web`=1, `bus_oeb`=1 and `bus_data_en`=1. Address and data keep the values they had in the hold phase.
- R6: Registers are written in index order. Register i uses address BASE_ADDR+i and data bits [i*DATA_W +: DATA_W] of REG_DATA. With the default parameters, the horizontal window register is written at 4'b0110 with data 8'h28, and then the vertical window register at 4'b0111 with data 8'h1E.
- R7: Outside the three write phases, the outputs are `bus_addr`=0, `bus_csb`=1, `bus_web`=1, `bus_oeb`=0, `bus_data_en`=0 and `bus_data`=0.
- R8: `setup_done` rises in the cycle after the last register's release phase ends. It stays high, with the bus idle, until reset.
- R9: A reset asserted in the middle of the sequence returns the outputs to their reset values at once. When reset is released again, the whole sequence restarts from the startup delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | output | ADDR_W | Register address on the camera bus |
| bus_data | output | DATA_W | Write data on the camera bus |
| bus_data_en | output | 1 | High while the data bus is driven |
| bus_csb | output | 1 | Chip select, active low |
| bus_web | output | 1 | Write enable, active low |
| bus_oeb | output | 1 | Output enable, active low |
| setup_done | output | 1 | Sequence complete, sticky until reset |

## Verification
The main function is checked cycle by cycle over a complete power-up run, from the startup delay to the completion flag. The run is compared against a table of segments whose lengths come from the wait count and the three phase lengths. A counting error of one cycle in any phase therefore shows up as a mismatch on the strobe or address pins. Two registers with different addresses and data values show whether the table index advances in order or repeats one entry. A reset applied during the second register's setup phase shows whether the startup delay and the register order restart from the beginning. A long idle stretch after completion shows whether the flag stays high and the bus stays quiet.

// File: rtl/cam_setup_pkg.sv
package cam_setup_pkg;
   typedef enum logic [2:0] {
      PH_WAIT    = 3'd0,
      PH_SETUP   = 3'd1,
      PH_HOLD    = 3'd2,
      PH_RELEASE = 3'd3,
      PH_FINISH  = 3'd4
   } phase_t;
endpackage

// File: rtl/cam_setup_timer.sv
module cam_setup_timer #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [CNT_W-1:0] limit,
   output logic             hit
);
   logic [CNT_W-1:0] count;

   assign hit = en && (count == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (hit)    count <= '0;
      else if (en)     count <= count + 1'b1;
   end
endmodule

// File: rtl/cam_setup_fsm.sv
module cam_setup_fsm
   import cam_setup_pkg::*;
#(
   parameter int NUM_REGS = 2,
   parameter int IDX_W    = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             hit,
   output phase_t           phase,
   output logic [IDX_W-1:0] idx
);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_REGS - 1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_WAIT;
         idx   <= '0;
      end else if (hit) begin
         unique case (phase)
            PH_WAIT:    phase <= PH_SETUP;
            PH_SETUP:   phase <= PH_HOLD;
            PH_HOLD:    phase <= PH_RELEASE;
            PH_RELEASE: begin
               if (idx == LAST_IDX) begin
                  phase <= PH_FINISH;
               end else begin
                  phase <= PH_SETUP;
                  idx   <= idx + 1'b1;
               end
            end
            default:    phase <= PH_FINISH;
         endcase
      end
   end
endmodule

// File: rtl/cam_setup_regtab.sv
module cam_setup_regtab #(
   parameter int                     NUM_REGS  = 2,
   parameter int                     IDX_W     = 1,
   parameter int                     ADDR_W    = 4,
   parameter int                     DATA_W    = 8,
   parameter logic [ADDR_W-1:0]      BASE_ADDR = 4'b0110,
   parameter logic [NUM_REGS*DATA_W-1:0] REG_DATA = '0
) (
   input  logic [IDX_W-1:0]  idx,
   output logic [ADDR_W-1:0] ent_addr,
   output logic [DATA_W-1:0] ent_data
);
   logic [ADDR_W-1:0] tab_addr [NUM_REGS];
   logic [DATA_W-1:0] tab_data [NUM_REGS];

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_entry
      assign tab_addr[i] = ADDR_W'(BASE_ADDR + ADDR_W'(i));
      assign tab_data[i] = REG_DATA[i*DATA_W +: DATA_W];
   end

   if (NUM_REGS == 1) begin : g_single
      assign ent_addr = tab_addr[0];
      assign ent_data = tab_data[0];
   end else begin : g_multi
      assign ent_addr = tab_addr[idx];
      assign ent_data = tab_data[idx];
   end
endmodule

// File: rtl/cam_setup_busdrv.sv
module cam_setup_busdrv
   import cam_setup_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  phase_t            phase,
   input  logic [ADDR_W-1:0] ent_addr,
   input  logic [DATA_W-1:0] ent_data,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_data_en,
   output logic              bus_csb,
   output logic              bus_web,
   output logic              bus_oeb,
   output logic              setup_done
);
   always_comb begin
      bus_addr    = '0;
      bus_data    = '0;
      bus_data_en = 1'b0;
      bus_csb     = 1'b1;
      bus_web     = 1'b1;
      bus_oeb     = 1'b0;
      setup_done  = (phase == PH_FINISH);
      unique case (phase)
         PH_SETUP, PH_HOLD: begin
            bus_addr    = ent_addr;
            bus_data    = ent_data;
            bus_data_en = 1'b1;
            bus_csb     = 1'b0;
            bus_web     = 1'b0;
            bus_oeb     = 1'b1;
         end
         PH_RELEASE: begin
            bus_addr    = ent_addr;
            bus_data    = ent_data;
            bus_data_en = 1'b1;
            bus_oeb     = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/cam_setup_seq.sv
module cam_setup_seq
   import cam_setup_pkg::*;
#(
   parameter int                         ADDR_W     = 4,
   parameter int                         DATA_W     = 8,
   parameter int                         NUM_REGS   = 2,
   parameter logic [ADDR_W-1:0]          BASE_ADDR  = 4'b0110,
   parameter logic [NUM_REGS*DATA_W-1:0] REG_DATA   = 16'h1E28,
   parameter int                         CNT_W      = 16,
   parameter int                         WAIT_COUNT = 5,
   parameter int                         T_SETUP    = 5,
   parameter int                         T_HOLD     = 3,
   parameter int                         T_RELEASE  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_data,
   output logic              bus_data_en,
   output logic              bus_csb,
   output logic              bus_web,
   output logic              bus_oeb,
   output logic              setup_done
);
   localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   if (NUM_REGS < 1) begin : g_bad_regs
      $error("NUM_REGS must be at least 1");
   end
   if (T_SETUP < 1 || T_HOLD < 1 || T_RELEASE < 1) begin : g_bad_phase
      $error("every phase must last at least one cycle");
   end
   if (WAIT_COUNT > CNT_MAX || T_SETUP > CNT_MAX + 1 ||
       T_HOLD > CNT_MAX + 1 || T_RELEASE > CNT_MAX + 1) begin : g_bad_cnt
      $error("CNT_W too narrow for the programmed counts");
   end
   if (int'(BASE_ADDR) + NUM_REGS > (1 << ADDR_W)) begin : g_bad_addr
      $error("register addresses exceed the address space");
   end

   phase_t            phase;
   logic [IDX_W-1:0]  idx;
   logic              hit;
   logic              tmr_en;
   logic [CNT_W-1:0]  limit;
   logic [ADDR_W-1:0] ent_addr;
   logic [DATA_W-1:0] ent_data;

   assign tmr_en = (phase != PH_FINISH);

   always_comb begin
      unique case (phase)
         PH_WAIT:    limit = CNT_W'(WAIT_COUNT);
         PH_SETUP:   limit = CNT_W'(T_SETUP - 1);
         PH_HOLD:    limit = CNT_W'(T_HOLD - 1);
         PH_RELEASE: limit = CNT_W'(T_RELEASE - 1);
         default:    limit = '0;
      endcase
   end

   cam_setup_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .en(tmr_en), .limit(limit), .hit(hit)
   );

   cam_setup_fsm #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .hit(hit), .phase(phase), .idx(idx)
   );

   cam_setup_regtab #(
      .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .BASE_ADDR(BASE_ADDR), .REG_DATA(REG_DATA)
   ) u_tab (
      .idx(idx), .ent_addr(ent_addr), .ent_data(ent_data)
   );

   cam_setup_busdrv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_drv (
      .phase(phase), .ent_addr(ent_addr), .ent_data(ent_data),
      .bus_addr(bus_addr), .bus_data(bus_data), .bus_data_en(bus_data_en),
      .bus_csb(bus_csb), .bus_web(bus_web), .bus_oeb(bus_oeb),
      .setup_done(setup_done)
   );
endmodule

// File: rtl/cam_setup_chk.sv
module cam_setup_chk #(
   parameter int                ADDR_W    = 4,
   parameter int                DATA_W    = 8,
   parameter int                NUM_REGS  = 2,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 4'b0110,
   parameter int                T_SETUP   = 5,
   parameter int                T_HOLD    = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_data,
   input logic              bus_data_en,
   input logic              bus_csb,
   input logic              bus_web,
   input logic              bus_oeb,
   input logic              setup_done
);
   localparam int LOW_LEN = T_SETUP + T_HOLD;

   logic [15:0] low_len;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        low_len <= '0;
      else if (!bus_csb) low_len <= low_len + 1'b1;
      else               low_len <= '0;
   end

   // R7: no data driven means idle bus levels
   p_idle_bus_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_data_en |-> (bus_csb && bus_web && !bus_oeb && bus_addr == '0 && bus_data == '0));

   // R4: write strobes move together with output enable off
   p_write_strobes_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_csb |-> (!bus_web && bus_oeb && bus_data_en));

   // R5: address and data steady through the write and into release
   p_hold_steady_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_csb && !$past(bus_csb)) |-> ($stable(bus_addr) && $stable(bus_data)));
   p_release_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_csb) |-> ($stable(bus_addr) && $stable(bus_data) && bus_data_en && bus_oeb));

   // R3: chip select low for setup plus hold cycles
   p_csb_low_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_csb) |-> (low_len == 16'(LOW_LEN)));

   // R6: addresses stay inside the register window
   p_addr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_en |-> (int'(bus_addr) >= int'(BASE_ADDR) &&
                       int'(bus_addr) < int'(BASE_ADDR) + NUM_REGS));

   // R8: completion sticky and bus quiet
   p_done_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      setup_done |=> setup_done);
   p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      setup_done |-> (bus_csb && !bus_data_en));
endmodule

bind cam_setup_seq cam_setup_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_REGS(NUM_REGS),
   .BASE_ADDR(BASE_ADDR), .T_SETUP(T_SETUP), .T_HOLD(T_HOLD)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
   .bus_data_en(bus_data_en), .bus_csb(bus_csb), .bus_web(bus_web),
   .bus_oeb(bus_oeb), .setup_done(setup_done)
);

// File: tb/cam_setup_seq_test.sv
module cam_setup_seq_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr;
   logic [7:0] bus_data;
   logic       bus_data_en, bus_csb, bus_web, bus_oeb, setup_done;

   int  total = 0;
   int  bad = 0;
   bit  finished = 1'b0;

   always #10 clk = ~clk;

   cam_setup_seq uut (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .bus_data_en(bus_data_en), .bus_csb(bus_csb), .bus_web(bus_web),
      .bus_oeb(bus_oeb), .setup_done(setup_done)
   );

   // vector: {addr[4], csb, web, oeb, den, data[8], done} = 17 bits
   localparam logic [16:0] IDLE  = {4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0};
   localparam logic [16:0] DONEV = {4'h0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1};
   localparam logic [16:0] H_WR  = {4'h6, 1'b0, 1'b0, 1'b1, 1'b1, 8'h28, 1'b0};
   localparam logic [16:0] H_REL = {4'h6, 1'b1, 1'b1, 1'b1, 1'b1, 8'h28, 1'b0};
   localparam logic [16:0] V_WR  = {4'h7, 1'b0, 1'b0, 1'b1, 1'b1, 8'h1E, 1'b0};
   localparam logic [16:0] V_REL = {4'h7, 1'b1, 1'b1, 1'b1, 1'b1, 8'h1E, 1'b0};

   // segments: {length[8], expected vector[17]}; wait=5 -> 6 idle cycles
   localparam logic [24:0] TAB [8] = '{
      {8'd6,  IDLE},
      {8'd5,  H_WR},
      {8'd3,  H_WR},
      {8'd1,  H_REL},
      {8'd5,  V_WR},
      {8'd3,  V_WR},
      {8'd1,  V_REL},
      {8'd10, DONEV}
   };

   function automatic string seg_req(int s);
      case (s)
         0: return "R2 R7 startup idle";
         1: return "R4 R6 horizontal setup";
         2: return "R3 R4 horizontal hold";
         3: return "R5 horizontal release";
         4: return "R6 vertical setup";
         5: return "R3 vertical hold";
         6: return "R5 vertical release";
         default: return "R8 done sticky";
      endcase
   endfunction

   function automatic logic [16:0] sample();
      return {bus_addr, bus_csb, bus_web, bus_oeb, bus_data_en, bus_data, setup_done};
   endfunction

   task automatic check(input logic [16:0] exp, input string req);
      logic [16:0] got;
      got = sample();
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s: got=%05h expected=%05h at %0t", req, got, exp, $time);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #2;
   endtask

   initial begin
      repeat (3) step();
      check(IDLE, "R1 reset state");
      rst_n = 1'b1;
      #1;
      // table walk over a full power-up sequence
      for (int s = 0; s < 8; s++) begin
         for (int j = 0; j < int'(TAB[s][24:17]); j++) begin
            check(TAB[s][16:0], seg_req(s));
            step();
         end
      end
      // R8: flag holds over a long idle stretch
      for (int j = 0; j < 40; j++) begin
         check(DONEV, "R8 done held");
         step();
      end
      // R9: reset in the middle of the second write
      rst_n = 1'b0;
      step();
      rst_n = 1'b1;
      for (int j = 0; j < 6 + 9 + 2; j++) step();
      check(V_WR, "R6 second register reached");
      rst_n = 1'b0;
      #1;
      check(IDLE, "R9 reset mid write");
      step();
      step();
      check(IDLE, "R1 held in reset");
      rst_n = 1'b1;
      for (int j = 0; j < 6; j++) begin
         check(IDLE, "R9 restart delay");
         step();
      end
      check(H_WR, "R9 restart first register");
      for (int j = 0; j < 8; j++) step();
      check(H_REL, "R9 restart release");
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 5000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: got=timeout expected=completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule